// File: doc/BRIEF.md
# Iterative AES-128 Inverse Cipher with Reverse Key Expansion

This block turns a 128-bit AES-128 ciphertext back into its plaintext. The key it receives is not the cipher key. It is the last round key, the one that encryption used in its final round. The block therefore runs the key expansion backwards, one round key per clock, while it works through the inverse rounds. When the ten rounds are complete, the plaintext and the original cipher key are both on the outputs.

Operation is load, then run. A load pulse captures the ciphertext and the last round key and applies the initial key whitening. A run request then starts the rounds, one per clock. Each round applies the inverse row rotation, the inverse byte substitution and the key addition. The inverse column mixing is applied in every round except the last. The done flag rises after the last round and stays high until the next load.

Top module: `aes128_inv_core`

## Requirements
- R1: While reset is active and after it is released, `done` is 0 and `plainOut` and `keyOut` are all zero.
- R2: A high `load` at a clock edge captures `cipherIn` and `lastKeyIn` and clears `done` by the next edge. `load` takes priority over `run` and abandons any decryption that is in progress.
- R3: Suppose a load has happened and `run` is sampled high for the first time at edge E. Then `done` is still 0 after 10 edges counting E, and it is 1 after 11 edges counting E.
- R4: When `done` is 1, `plainOut` holds the AES-128 inverse cipher of the loaded ciphertext. Byte n of a block sits in bits [127-8n -: 8], and the state is filled column by column with row = n mod 4 and column = n div 4.
- R5: When `done` is 1, `keyOut` holds the original cipher key. It is rebuilt by undoing the key expansion with the round constants taken in reverse order: 36, 1B, 80, 40, 20, 10, 08, 04, 02, 01.
- R6: Once `done` is 1, it stays 1 and `plainOut` and `keyOut` hold their values until the next load, whatever `run` does.
- R7: If no load has happened since reset, `run` has no effect: `done` stays 0 and both outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture ciphertext and last round key |
| run | input | 1 | Start the inverse rounds after a load |
| cipherIn | input | 128 | Ciphertext block |
| lastKeyIn | input | 128 | Round key of the final encryption round |
| plainOut | output | 128 | Recovered plaintext (valid while done) |
| keyOut | output | 128 | Recovered cipher key (valid while done) |
| done | output | 1 | Decryption complete |

## Verification
The bench builds the core with its default of ten rounds, which is the only round count AES-128 defines. With that setting, published known-answer vectors can serve as ground truth for both the plaintext and the recovered key. Two such vectors use unrelated keys, so every round constant and every byte of the substitution path is exercised against values computed outside the design. Directed sequences cover the exact cycle on which done rises, a load that arrives in the middle of a run, load and run asserted together, and a run with nothing loaded.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

  localparam int IDX_W = 4;

  typedef struct packed {
    logic             capture;
    logic             step;
    logic             lastRound;
    logic [IDX_W-1:0] roundIdx;
  } ctlStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254, square-and-multiply
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gfMul(r, r);
      if (i != 0) r = gfMul(r, a);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] fwdSub(input logic [7:0] a);
    logic [7:0] b;
    b = gfInv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] invSub(input logic [7:0] a);
    return gfInv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  function automatic logic [7:0] rconOf(input logic [4:0] j);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++)
      if (5'(i) < j) r = xtime(r);
    return r;
  endfunction

  // row r rotated right by r positions, then per-byte inverse substitution
  function automatic logic [127:0] invShiftSub(input logic [127:0] s);
    logic [127:0] o;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        o[127-8*(r+4*c) -: 8] = invSub(s[127-8*(r+4*((c-r+4)%4)) -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] invMix(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = gfMul(a0,8'h0e)^gfMul(a1,8'h0b)^gfMul(a2,8'h0d)^gfMul(a3,8'h09);
      o[119-32*c -: 8] = gfMul(a0,8'h09)^gfMul(a1,8'h0e)^gfMul(a2,8'h0b)^gfMul(a3,8'h0d);
      o[111-32*c -: 8] = gfMul(a0,8'h0d)^gfMul(a1,8'h09)^gfMul(a2,8'h0e)^gfMul(a3,8'h0b);
      o[103-32*c -: 8] = gfMul(a0,8'h0b)^gfMul(a1,8'h0d)^gfMul(a2,8'h09)^gfMul(a3,8'h0e);
    end
    return o;
  endfunction

  // one step back through the key expansion
  function automatic logic [127:0] prevKey(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, p1, p2, p3, t;
    w0 = k[127:96]; w1 = k[95:64]; w2 = k[63:32]; w3 = k[31:0];
    p3 = w3 ^ w2;
    p2 = w2 ^ w1;
    p1 = w1 ^ w0;
    t  = {fwdSub(p3[23:16]) ^ rc, fwdSub(p3[15:8]), fwdSub(p3[7:0]), fwdSub(p3[31:24])};
    return {w0 ^ t, p1, p2, p3};
  endfunction

endpackage

// File: rtl/aes_inv_ctrl.sv
module aes_inv_ctrl
  import aes_inv_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic        run,
  output ctlStrobes_t ctl,
  output logic        done
);
  typedef enum logic [1:0] {ST_EMPTY, ST_ARMED, ST_BUSY, ST_FIN} ctlState_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);

  ctlState_t        st;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= ST_EMPTY;
      cnt <= '0;
    end else if (load) begin
      st  <= ST_ARMED;
      cnt <= '0;
    end else begin
      case (st)
        ST_ARMED: if (run) begin
          st  <= ST_BUSY;
          cnt <= '0;
        end
        ST_BUSY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) st <= ST_FIN;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.capture   = load;
    ctl.step      = (st == ST_BUSY) && !load;
    ctl.lastRound = (cnt == LAST_IDX);
    ctl.roundIdx  = cnt;
  end

  assign done = (st == ST_FIN);
endmodule

// File: rtl/aes_inv_datapath.sv
module aes_inv_datapath
  import aes_inv_pkg::*;
#(
  parameter int ROUNDS  = 10,
  parameter int BLOCK_W = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [BLOCK_W-1:0] cipherIn,
  input  logic [BLOCK_W-1:0] lastKeyIn,
  output logic [BLOCK_W-1:0] stateOut,
  output logic [BLOCK_W-1:0] keyOut
);
  logic [BLOCK_W-1:0] stateQ, keyQ, keyPrev, roundVal;
  logic [4:0]         rcIdx;

  assign rcIdx    = 5'(ROUNDS) - {1'b0, ctl.roundIdx};
  assign keyPrev  = prevKey(keyQ, rconOf(rcIdx));
  assign roundVal = invShiftSub(stateQ) ^ keyPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      keyQ   <= '0;
    end else if (ctl.capture) begin
      stateQ <= cipherIn ^ lastKeyIn;
      keyQ   <= lastKeyIn;
    end else if (ctl.step) begin
      stateQ <= ctl.lastRound ? roundVal : invMix(roundVal);
      keyQ   <= keyPrev;
    end
  end

  assign stateOut = stateQ;
  assign keyOut   = keyQ;
endmodule

// File: rtl/aes128_inv_core.sv
module aes128_inv_core
  import aes_inv_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         run,
  input  logic [127:0] cipherIn,
  input  logic [127:0] lastKeyIn,
  output logic [127:0] plainOut,
  output logic [127:0] keyOut,
  output logic         done
);
  ctlStrobes_t ctl;

  aes_inv_ctrl #(.ROUNDS(ROUNDS)) uCtrl (
    .clk(clk), .rstN(rstN), .load(load), .run(run), .ctl(ctl), .done(done)
  );

  aes_inv_datapath #(.ROUNDS(ROUNDS), .BLOCK_W(128)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cipherIn(cipherIn), .lastKeyIn(lastKeyIn),
    .stateOut(plainOut), .keyOut(keyOut)
  );
endmodule

// File: rtl/aes128_inv_chk.sv
module aes128_inv_chk (
  input logic         clk,
  input logic         rstN,
  input logic         load,
  input logic         run,
  input logic [127:0] plainOut,
  input logic [127:0] keyOut,
  input logic         done
);
  logic seenLoad;

  always_ff @(posedge clk) begin
    if (!rstN) seenLoad <= 1'b0;
    else if (load) seenLoad <= 1'b1;
  end

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !done); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    done && !load |=> done); // R6
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    done && !load |=> $stable(plainOut) && $stable(keyOut)); // R6
  AST_NO_DONE_UNLOADED: assert property (@(posedge clk) disable iff (!rstN)
    !seenLoad |-> !done && plainOut == '0 && keyOut == '0); // R7
  AST_DONE_NEEDS_QUIET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !$past(load)); // R3
endmodule

bind aes128_inv_core aes128_inv_chk uChk (
  .clk(clk), .rstN(rstN), .load(load), .run(run),
  .plainOut(plainOut), .keyOut(keyOut), .done(done)
);

// File: tb/tb_aes128_inv_core.sv
module tb_aes128_inv_core;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         load = 1'b0;
  logic         run = 1'b0;
  logic [127:0] cipherIn = '0;
  logic [127:0] lastKeyIn = '0;
  logic [127:0] plainOut, keyOut;
  logic         done;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  aes128_inv_core dut (
    .clk(clk), .rstN(rstN), .load(load), .run(run), .cipherIn(cipherIn),
    .lastKeyIn(lastKeyIn), .plainOut(plainOut), .keyOut(keyOut), .done(done)
  );

  // {ciphertext, last round key, plaintext, cipher key}
  localparam logic [511:0] VEC [2] = '{
    {128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h13111d7fe3944a17f307a78b4d2b30c5,
     128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f},
    {128'h3925841d02dc09fbdc118597196a0b32, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
     128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [127:0] ct, input logic [127:0] k, input logic withRun);
    @(negedge clk);
    load = 1'b1; run = withRun; cipherIn = ct; lastKeyIn = k;
    @(negedge clk);
    load = 1'b0; run = 1'b0;
  endtask

  // run sampled at the next edge E; done low after 10 edges, high after 11
  task automatic runTimed(input string tag);
    run = 1'b1;
    repeat (10) @(negedge clk);
    check({tag, " R3 done low after 10 edges"}, {127'd0, done}, 128'd0);
    @(negedge clk);
    check({tag, " R3 done high after 11 edges"}, {127'd0, done}, 128'd1);
    run = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done in reset", {127'd0, done}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 done after reset", {127'd0, done}, 128'd0);
    check("R1 plainOut zero", plainOut, 128'd0);
    check("R1 keyOut zero", keyOut, 128'd0);

    // R7: run with nothing loaded
    run = 1'b1;
    repeat (14) @(negedge clk);
    run = 1'b0;
    check("R7 done without load", {127'd0, done}, 128'd0);
    check("R7 plainOut untouched", plainOut, 128'd0);

    // vector table
    for (int v = 0; v < 2; v++) begin
      doLoad(VEC[v][511:384], VEC[v][383:256], 1'b0);
      check("R2 done cleared by load", {127'd0, done}, 128'd0);
      runTimed($sformatf("vec%0d", v));
      check($sformatf("R4 plaintext vec%0d", v), plainOut, VEC[v][255:128]);
      check($sformatf("R5 cipher key vec%0d", v), keyOut, VEC[v][127:0]);
    end

    // R6: hold under run activity
    run = 1'b1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 done held", {127'd0, done}, 128'd1);
    check("R6 plaintext held", plainOut, VEC[1][255:128]);
    check("R6 key held", keyOut, VEC[1][127:0]);

    // R2: load and run together, load wins, run later
    doLoad(VEC[0][511:384], VEC[0][383:256], 1'b1);
    check("R2 load beats run", {127'd0, done}, 128'd0);
    runTimed("both");
    check("R4 plaintext after joint load", plainOut, VEC[0][255:128]);

    // R2: load in mid-run abandons it
    doLoad(VEC[0][511:384], VEC[0][383:256], 1'b0);
    run = 1'b1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    doLoad(VEC[1][511:384], VEC[1][383:256], 1'b0);
    repeat (12) @(negedge clk);
    check("R2 aborted run not done", {127'd0, done}, 128'd0);
    runTimed("abort");
    check("R4 plaintext after abort", plainOut, VEC[1][255:128]);
    check("R5 key after abort", keyOut, VEC[1][127:0]);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule